// File: doc/BRIEF.md
# Peripheral I/O Bus Cycle Sequencer

This block is the master side of a slow, byte-wide peripheral bus that works much like ISA. A synchronous host hands it one read or one write at a time. The block turns each request into a timed bus cycle with four phases: address setup, strobe, hold and back to idle. During the strobe window exactly one of four chip-select lines is driven, so the peripherals need no external decoder. The four address lines only pick a register inside the selected peripheral.

Every phase length is a parameter counted in clock cycles. The defaults assume a 10 ns clock and give these lengths:

| Phase | Read | Write |
|---|---|---|
| Address setup | 36 | 36 |
| Strobe | 54 | 66 |
| Hold | 33 | 33 |
| Total | 123 | 135 |

A write is longer than a read only because its strobe is longer. A slow peripheral pulls the channel-ready input low to hold the strobe phase open. That input first passes through a two-stage synchronizer. On writes, the data pins are driven during a window tied to the trailing edge of the write strobe. On reads, the byte on the data pins is captured just before the read strobe ends and handed back with a one-cycle done pulse.

Top module: `iobus_seq`

## Requirements
- R1: After reset, and whenever reset is asserted in the middle of a cycle, the block is idle at its pins. Both strobes are high, all chip selects are high, the data output enable is 0, the address is 0, done is 0 and req_ready is 1.
- R2: A request is taken only at a clock edge where req_ready is 1 and req_valid is 1; req_ready is 1 only when the block is idle. A req_valid pulse during a busy cycle starts no cycle and does not change the running cycle's address, select or direction.
- R3: From the edge that takes the request until the end of the hold phase, bus_addr carries the requested address without change. At all other times bus_addr is 0. The address is valid for SETUP_CYC cycles before either strobe goes low.
- R4: Chip select number k is bus_cs_n bit k, active low, with k taken from req_sel. It is low exactly in the cycles where a strobe is low, and at most one chip select is ever low.
- R5: A read drives only bus_rd_n low and a write drives only bus_wr_n low. The two strobes are never low in the same cycle.
- R6: With bus_chrdy high, the read strobe lasts STROBE_CYC cycles and the write strobe lasts STROBE_CYC+WR_EXTRA_CYC cycles.
- R7: After the strobe ends, the hold phase lasts HOLD_CYC cycles and the block is then idle. A read keeps req_ready low for SETUP_CYC+STROBE_CYC+HOLD_CYC cycles, and a write keeps it low for WR_EXTRA_CYC cycles longer.
- R8: bus_chrdy goes through a two-flop synchronizer. While the synchronized value is low, the strobe cannot end even after its nominal width has passed. If bus_chrdy rises in strobe cycle c, at or after the nominal width, the strobe lasts c+2 cycles. A low pulse on bus_chrdy that is over well before the nominal end of the strobe does not lengthen it.
- R9: For a read, rd_data takes the value of bus_data_i in the last strobe cycle. It shows that value with done and keeps it until the next read finishes; writes leave it unchanged.
- R10: done is high for exactly one cycle, the first idle cycle after the hold phase.
- R11: bus_data_oe is high only during writes. It rises WR_SETUP_CYC cycles before bus_wr_n rises, plus any wait cycles, and stays high for WR_HOLD_CYC cycles after that. bus_data_o equals the request's write data whenever bus_data_oe is high. During reads it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_sel | input | 2 | Index of the chip select to drive |
| req_addr | input | 4 | Register address inside the peripheral |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Idle, a request is taken at this edge |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last byte read |
| bus_addr | output | 4 | Bus address lines |
| bus_cs_n | output | 4 | Active-low chip selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_data_o | output | 8 | Data driven toward the bus |
| bus_data_oe | output | 1 | Output enable for bus_data_o |
| bus_data_i | input | 8 | Data received from the bus |
| bus_chrdy | input | 1 | Channel ready from the peripheral, low inserts waits |

## Verification
The table of transactions covers reads and writes on every chip select with different addresses and bytes. It separates the read and write strobe widths, and shows whether the address is held through the hold phase. Some entries hold channel-ready low by different amounts, which shows that a stretch adds exactly the synchronizer delay and moves the start of write-data drive with the strobe end. On reads the bench changes bus_data_i only in the final strobe cycle, so a capture one edge early is caught. Directed cases cover a short ready glitch that must not stretch the strobe, a request raised while busy, and a reset taken in the middle of a cycle.

// File: rtl/iobus_pkg.sv
package iobus_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

endpackage

// File: rtl/iobus_sync.sv
module iobus_sync #(
    parameter int       STAGES  = 2,
    parameter logic     RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d;
        end else begin : g_chain
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/iobus_phase_ctl.sv
module iobus_phase_ctl
    import iobus_pkg::*;
#(
    parameter int SETUP_CYC    = 36,
    parameter int STROBE_CYC   = 54,
    parameter int WR_EXTRA_CYC = 12,
    parameter int HOLD_CYC     = 33,
    parameter int CNT_W        = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             rdy_sync,
    output phase_e           ph_q,
    output phase_e           ph_d,
    output logic [CNT_W-1:0] cnt_d,
    output logic             wr_d
);
    localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LAST    = CNT_W'(STROBE_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LAST    = CNT_W'(STROBE_CYC + WR_EXTRA_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic             wr;
    } ctl_t;

    ctl_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    r_d.ph  = PH_SETUP;
                    r_d.cnt = SETUP_LAST;
                    r_d.wr  = req_write;
                end
            end
            PH_SETUP: begin
                if (r_q.cnt == '0) begin
                    r_d.ph  = PH_STROBE;
                    r_d.cnt = r_q.wr ? WR_LAST : RD_LAST;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                // count down the nominal width, then wait for ready
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else if (rdy_sync) begin
                    r_d.ph  = PH_HOLD;
                    r_d.cnt = HOLD_LAST;
                end
            end
            PH_HOLD: begin
                if (r_q.cnt == '0) r_d.ph  = PH_IDLE;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{ph: PH_IDLE, cnt: '0, wr: 1'b0};
        else        r_q <= r_d;
    end

    assign ph_q  = r_q.ph;
    assign ph_d  = r_d.ph;
    assign cnt_d = r_d.cnt;
    assign wr_d  = r_d.wr;

    // direction of a running cycle never changes (R2)
    assert_dir_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph != PH_IDLE) |=> $stable(r_q.wr));

    // a low synchronized ready keeps the strobe phase open (R8)
    assert_wait_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_STROBE && !rdy_sync) |=> (r_q.ph == PH_STROBE));
endmodule

// File: rtl/iobus_pins.sv
module iobus_pins
    import iobus_pkg::*;
#(
    parameter int HOLD_CYC     = 33,
    parameter int WR_SETUP_CYC = 30,
    parameter int WR_HOLD_CYC  = 10,
    parameter int CNT_W        = 7,
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 4,
    parameter int NUM_CS       = 4,
    parameter int SEL_W        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            ph_q,
    input  phase_e            ph_d,
    input  logic [CNT_W-1:0]  cnt_d,
    input  logic              wr_d,
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_data_i,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [NUM_CS-1:0] bus_cs_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              bus_data_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);
    localparam logic [CNT_W-1:0] OE_LEAD  = CNT_W'(WR_SETUP_CYC);
    localparam logic [CNT_W-1:0] OE_TRAIL = CNT_W'(HOLD_CYC - WR_HOLD_CYC);

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [NUM_CS-1:0] cs_n;
        logic              rd_n;
        logic              wr_n;
        logic              oe;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } pin_t;

    pin_t r_d, r_q;
    logic accept, strobe_nx, lead_win, trail_win;

    always_comb begin
        r_d       = r_q;
        accept    = (ph_q == PH_IDLE) && req_valid;
        strobe_nx = (ph_d == PH_STROBE);

        if (accept) begin
            r_d.sel   = req_sel;
            r_d.addr  = req_addr;
            r_d.wdata = req_wdata;
        end else if (ph_d == PH_IDLE) begin
            r_d.addr  = '0;
        end

        r_d.rd_n = !(strobe_nx && !wr_d);
        r_d.wr_n = !(strobe_nx &&  wr_d);
        for (int k = 0; k < NUM_CS; k++) begin
            r_d.cs_n[k] = !(strobe_nx && (r_d.sel == SEL_W'(k)));
        end

        lead_win  = strobe_nx && (cnt_d < OE_LEAD);
        trail_win = (ph_d == PH_HOLD) && (cnt_d >= OE_TRAIL);
        r_d.oe    = wr_d && (lead_win || trail_win);

        if (ph_q == PH_STROBE && ph_d == PH_HOLD && !wr_d) begin
            r_d.rdata = bus_data_i;
        end
        r_d.done = (ph_q == PH_HOLD) && (ph_d == PH_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.cs_n <= '1;
            r_q.rd_n <= 1'b1;
            r_q.wr_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_addr    = r_q.addr;
    assign bus_cs_n    = r_q.cs_n;
    assign bus_rd_n    = r_q.rd_n;
    assign bus_wr_n    = r_q.wr_n;
    assign bus_data_o  = r_q.wdata;
    assign bus_data_oe = r_q.oe;
    assign rd_data     = r_q.rdata;
    assign done        = r_q.done;

    assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_n || bus_wr_n));

    assert_cs_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_cs_n));

    assert_oe_not_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_oe |-> bus_rd_n);

    assert_wdata_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_data_oe && $past(bus_data_oe)) |-> $stable(bus_data_o));
endmodule

// File: rtl/iobus_seq.sv
module iobus_seq
    import iobus_pkg::*;
#(
    parameter int SETUP_CYC    = 36,
    parameter int STROBE_CYC   = 54,
    parameter int WR_EXTRA_CYC = 12,
    parameter int HOLD_CYC     = 33,
    parameter int WR_SETUP_CYC = 30,
    parameter int WR_HOLD_CYC  = 10,
    parameter int SYNC_STAGES  = 2,
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 4,
    parameter int NUM_CS       = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [$clog2(NUM_CS)-1:0] req_sel,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic                      req_ready,
    output logic                      done,
    output logic [DATA_W-1:0]         rd_data,
    output logic [ADDR_W-1:0]         bus_addr,
    output logic [NUM_CS-1:0]         bus_cs_n,
    output logic                      bus_rd_n,
    output logic                      bus_wr_n,
    output logic [DATA_W-1:0]         bus_data_o,
    output logic                      bus_data_oe,
    input  logic [DATA_W-1:0]         bus_data_i,
    input  logic                      bus_chrdy
);
    localparam int SEL_W     = $clog2(NUM_CS);
    localparam int WR_STROBE = STROBE_CYC + WR_EXTRA_CYC;
    localparam int MAX_A     = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int MAX_PH    = (MAX_A > WR_STROBE) ? MAX_A : WR_STROBE;
    localparam int CNT_W     = $clog2(MAX_PH + 1);

    phase_e           ph_q, ph_d;
    logic [CNT_W-1:0] cnt_d;
    logic             wr_d;
    logic             rdy_sync;

    iobus_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) i_rdy_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_chrdy),
        .q     (rdy_sync)
    );

    iobus_phase_ctl #(
        .SETUP_CYC    (SETUP_CYC),
        .STROBE_CYC   (STROBE_CYC),
        .WR_EXTRA_CYC (WR_EXTRA_CYC),
        .HOLD_CYC     (HOLD_CYC),
        .CNT_W        (CNT_W)
    ) i_phase_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .rdy_sync  (rdy_sync),
        .ph_q      (ph_q),
        .ph_d      (ph_d),
        .cnt_d     (cnt_d),
        .wr_d      (wr_d)
    );

    iobus_pins #(
        .HOLD_CYC     (HOLD_CYC),
        .WR_SETUP_CYC (WR_SETUP_CYC),
        .WR_HOLD_CYC  (WR_HOLD_CYC),
        .CNT_W        (CNT_W),
        .DATA_W       (DATA_W),
        .ADDR_W       (ADDR_W),
        .NUM_CS       (NUM_CS),
        .SEL_W        (SEL_W)
    ) i_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .ph_q        (ph_q),
        .ph_d        (ph_d),
        .cnt_d       (cnt_d),
        .wr_d        (wr_d),
        .req_valid   (req_valid),
        .req_sel     (req_sel),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .bus_data_i  (bus_data_i),
        .bus_addr    (bus_addr),
        .bus_cs_n    (bus_cs_n),
        .bus_rd_n    (bus_rd_n),
        .bus_wr_n    (bus_wr_n),
        .bus_data_o  (bus_data_o),
        .bus_data_oe (bus_data_oe),
        .rd_data     (rd_data),
        .done        (done)
    );

    assign req_ready = (ph_q == PH_IDLE);

    // strobe width monitor: consecutive low-strobe cycles, saturating
    logic [CNT_W-1:0] strb_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       strb_len_q <= '0;
        else if (bus_rd_n && bus_wr_n)    strb_len_q <= '0;
        else if (strb_len_q != '1)        strb_len_q <= strb_len_q + 1'b1;
    end

    assert_rd_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rd_n) |-> (strb_len_q >= CNT_W'(STROBE_CYC)));

    assert_wr_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr_n) |-> (strb_len_q >= CNT_W'(WR_STROBE)));

    assert_cs_with_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_cs_n != '1) == (!bus_rd_n || !bus_wr_n)));

    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(bus_addr));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/test_iobus_seq.sv
module test_iobus_seq;
    localparam int S  = 36;
    localparam int L  = 54;
    localparam int WX = 12;
    localparam int H  = 33;
    localparam int WS = 30;
    localparam int WH = 10;

    typedef struct packed {
        logic       wr;
        logic [1:0] sel;
        logic [3:0] addr;
        logic [7:0] wdata;
        logic [7:0] resp;
        logic [7:0] stall;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 4'h3, 8'h00, 8'hA5, 8'd0},
        '{1'b1, 2'd1, 4'hC, 8'h3C, 8'h00, 8'd0},
        '{1'b0, 2'd2, 4'hF, 8'h00, 8'h5A, 8'd7},
        '{1'b1, 2'd3, 4'h1, 8'hC3, 8'h00, 8'd4},
        '{1'b0, 2'd3, 4'h8, 8'h00, 8'h00, 8'd0},
        '{1'b1, 2'd0, 4'h6, 8'hFF, 8'h00, 8'd1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [1:0] req_sel = 2'd0;
    logic [3:0] req_addr = 4'h0;
    logic [7:0] req_wdata = 8'h00;
    logic       req_ready, done;
    logic [7:0] rd_data;
    logic [3:0] bus_addr;
    logic [3:0] bus_cs_n;
    logic       bus_rd_n, bus_wr_n;
    logic [7:0] bus_data_o;
    logic       bus_data_oe;
    logic [7:0] bus_data_i = 8'h00;
    logic       bus_chrdy = 1'b1;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] last_rd = 8'h00;

    always #5 clk = ~clk;

    iobus_seq i_iobus_seq (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_write (req_write), .req_sel (req_sel),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .req_ready (req_ready), .done (done), .rd_data (rd_data),
        .bus_addr (bus_addr), .bus_cs_n (bus_cs_n),
        .bus_rd_n (bus_rd_n), .bus_wr_n (bus_wr_n),
        .bus_data_o (bus_data_o), .bus_data_oe (bus_data_oe),
        .bus_data_i (bus_data_i), .bus_chrdy (bus_chrdy)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check(req, "rd_n high", int'(bus_rd_n), 1);
        check(req, "wr_n high", int'(bus_wr_n), 1);
        check(req, "cs_n all high", int'(bus_cs_n), 15);
        check(req, "oe low", int'(bus_data_oe), 0);
        check(req, "addr zero", int'(bus_addr), 0);
        check(req, "ready high", int'(req_ready), 1);
    endtask

    // glitch: short ready-low pulse early in strobe; poke: req_valid while busy
    task automatic run_txn(input vec_t v, input bit glitch, input bit poke);
        int busy = 0, setup = 0, strb = 0, oe_in = 0, oe_out = 0;
        int cs_err = 0, addr_err = 0, data_err = 0, wrong = 0;
        int exp_l, eff_l;
        bit seen = 1'b0;
        logic strobe_now;
        logic [3:0] exp_cs;
        exp_l = v.wr ? L + WX : L;
        eff_l = (v.stall != 0) ? exp_l + int'(v.stall) + 2 : exp_l;
        @(negedge clk);
        req_valid = 1'b1; req_write = v.wr; req_sel = v.sel;
        req_addr = v.addr; req_wdata = v.wdata;
        bus_chrdy = (v.stall == 0);
        bus_data_i = ~v.resp;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~v.addr; req_wdata = ~v.wdata; req_sel = ~v.sel;
        while (!req_ready && busy < 1000) begin
            busy++;
            strobe_now = !bus_rd_n || !bus_wr_n;
            if (v.wr ? !bus_rd_n : !bus_wr_n) wrong++;
            if (strobe_now) begin seen = 1'b1; strb++; end
            else if (!seen) setup++;
            exp_cs = strobe_now ? ~(4'b0001 << v.sel) : 4'hF;
            if (bus_cs_n != exp_cs) cs_err++;
            if (bus_addr != v.addr) addr_err++;
            if (bus_data_oe) begin
                if (strobe_now) oe_in++; else oe_out++;
                if (bus_data_o != v.wdata) data_err++;
            end
            bus_data_i = (strobe_now && strb == eff_l) ? v.resp : ~v.resp;
            if (v.stall != 0 && strb == exp_l + int'(v.stall)) bus_chrdy = 1'b1;
            if (glitch) bus_chrdy = !(strb >= 1 && strb <= 5);
            if (poke && busy == 10) begin
                req_valid = 1'b1; req_write = !v.wr; req_addr = 4'h9; req_sel = v.sel + 2'd1;
            end
            if (poke && busy == 11) req_valid = 1'b0;
            @(negedge clk);
        end
        if (!v.wr) last_rd = v.resp;
        check("R7", "busy cycles", busy, S + eff_l + H);
        check("R3", "address setup cycles", setup, S);
        check(v.stall != 0 ? "R8" : "R6", "strobe cycles", strb, eff_l);
        check("R7", "hold cycles", busy - setup - strb, H);
        check("R4", "chip select mismatches", cs_err, 0);
        check("R3", "address mismatches", addr_err, 0);
        check("R5", "wrong strobe cycles", wrong, 0);
        if (v.wr) begin
            check("R11", "oe cycles with strobe", oe_in, WS + eff_l - exp_l);
            check("R11", "oe cycles after strobe", oe_out, WH);
            check("R11", "write data mismatches", data_err, 0);
        end else begin
            check("R11", "oe cycles on read", oe_in + oe_out, 0);
        end
        check("R10", "done in first idle cycle", int'(done), 1);
        check("R9", "rd_data", int'(rd_data), int'(last_rd));
        check("R3", "addr zero when idle", int'(bus_addr), 0);
        @(negedge clk);
        check("R10", "done cleared after one cycle", int'(done), 0);
        bus_chrdy = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check_idle("R1");
        check("R1", "done low in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");

        for (int i = 0; i < NV; i++) run_txn(VECS[i], 1'b0, 1'b0);

        // R8: short ready glitch early in the strobe must not stretch it
        run_txn('{1'b0, 2'd1, 4'h7, 8'h00, 8'h69, 8'd0}, 1'b1, 1'b0);

        // R2: a request raised while busy is ignored
        run_txn('{1'b1, 2'd2, 4'h4, 8'h96, 8'h00, 8'd0}, 1'b0, 1'b1);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R2", "no extra cycle after busy request", int'(req_ready && bus_rd_n && bus_wr_n), 1);
        end
        check("R9", "rd_data kept across writes", int'(rd_data), int'(last_rd));

        // R1: reset asserted in the middle of a write strobe
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_sel = 2'd2; req_addr = 4'hB; req_wdata = 8'h11;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (S + 40) @(negedge clk);
        check("R1", "strobe active before mid-cycle reset", int'(bus_wr_n), 0);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule